// File: doc/BRIEF.md
# Segmented Serial Shift Register with Tap Loading

This block is a long serial delay line built from equal-length segments, with a tap at the last stage of every segment. In shift mode it behaves as one continuous register: every rising clock edge moves each bit one stage further, and each tap shows the content of its stage. The default is 64 stages in four 16-stage segments, so the taps sit at stages 16, 32, 48 and 64.

When the write-enable input is high, all tap output enables drop. The first stage of every segment except the first then takes its bit from that segment's own tap input instead of from the stage before it. The serial input still feeds stage 1 in both modes. Four serial streams can therefore fill the whole register in one segment length of clocks: 16 clocks instead of 64. The last tap is output-only.

Each tap appears as a value output and an enable output, and the intermediate taps also have an input. This lets the integrator build a shared bidirectional line at the chip edge.

Top module: `tapped_shift_reg`

## Requirements
- R1: While the active-low reset `rst_n` is low, every stage is cleared asynchronously, so all bits of `tap_out` read 0.
- R2: On every rising clock edge out of reset, stage 1 takes the value of `ser_in`, whatever the level of `wr_en`.
- R3: All bits of `tap_oe` are 1 when `wr_en` is 0 and all are 0 when `wr_en` is 1. The change is combinational, with no clock delay.
- R4: When `wr_en` is 1 at a rising edge, stage 16k+1 (k = 1, 2, 3) takes `tap_in[k-1]`. It does not take stage 16k.
- R5: When `wr_en` is 0 at a rising edge, `tap_in` has no effect, and stage 16k+1 takes the old value of stage 16k.
- R6: `tap_out[k]` always shows the content of stage 16(k+1): bit 0 is stage 16 and bit 3 is stage 64, in both modes. Stage 64 has no tap input.
- R7: In shift mode every stage takes the old value of the stage before it on each rising edge. A bit applied at `ser_in` therefore appears on `tap_out[3]` after 64 rising edges.
- R8: After 16 write-mode clocks, stage 16k+16-n holds the bit driven on stream k at write clock n (n = 0..15). Stream 0 is `ser_in` and stream k is `tap_in[k-1]`. The loaded word is then read back in order on `tap_out[3]` over 64 shift-mode clocks, starting with stage 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| ser_in | input | 1 | Serial data into stage 1 |
| wr_en | input | 1 | 1 selects segment loading and disables the taps |
| tap_in | input | NUM_SEGS-1 | External bits for the first stage of segments 1..3 while writing |
| tap_out | output | NUM_SEGS | Content of the last stage of each segment |
| tap_oe | output | NUM_SEGS | Drive enable for each tap, active in shift mode |

## Verification
The checker assumes that `wr_en`, `ser_in` and `tap_in` are stable around each rising edge. It also assumes that reset is released away from a clock edge, so the value compared one cycle later through `$past` is the one the flops captured. The bench changes every input only on the falling edge and releases reset there too. Random `tap_in` values are applied during shift mode so that ignoring them is visible at the taps. `wr_en` is toggled freely so that both segment-feed paths are used on back-to-back clocks.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } tsr_mode_e;

  // Mode derived from the write-enable level.
  function automatic tsr_mode_e mode_of(input logic wr);
    return wr ? MODE_LOAD : MODE_SHIFT;
  endfunction

  // Source of a segment's first stage: external tap in load mode,
  // the previous segment's tail in shift mode.
  function automatic logic seg_feed(input tsr_mode_e mode,
                                    input logic ext_bit,
                                    input logic chain_bit);
    return (mode == MODE_LOAD) ? ext_bit : chain_bit;
  endfunction

  // A tap drives its line only in shift mode.
  function automatic logic tap_enable(input tsr_mode_e mode);
    return (mode == MODE_SHIFT);
  endfunction

endpackage

// File: rtl/tsr_segment.sv
module tsr_segment #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic head,
  output logic tail
);

  logic [LEN-1:0] stages;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stages <= '0;
        else        stages <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stages <= '0;
        else        stages <= {stages[LEN-2:0], din};
      end
    end
  endgenerate

  assign head = stages[0];
  assign tail = stages[LEN-1];

endmodule

// File: rtl/tsr_feed_mux.sv
module tsr_feed_mux
  import tsr_pkg::*;
#(
  parameter int NUM_SEGS = 4
) (
  input  tsr_mode_e            mode,
  input  logic                 ser_in,
  input  logic [NUM_SEGS-2:0]  tap_in,
  input  logic [NUM_SEGS-1:0]  seg_tail,
  output logic [NUM_SEGS-1:0]  seg_din
);

  assign seg_din[0] = ser_in;

  genvar k;
  generate
    for (k = 1; k < NUM_SEGS; k++) begin : g_feed
      assign seg_din[k] = seg_feed(mode, tap_in[k-1], seg_tail[k-1]);
    end
  endgenerate

endmodule

// File: rtl/tsr_tap_ctrl.sv
module tsr_tap_ctrl
  import tsr_pkg::*;
#(
  parameter int NUM_SEGS = 4
) (
  input  logic                wr_en,
  output tsr_mode_e           mode,
  output logic [NUM_SEGS-1:0] tap_oe
);

  assign mode = mode_of(wr_en);

  genvar k;
  generate
    for (k = 0; k < NUM_SEGS; k++) begin : g_oe
      assign tap_oe[k] = tap_enable(mode);
    end
  endgenerate

endmodule

// File: rtl/tapped_shift_reg.sv
module tapped_shift_reg
  import tsr_pkg::*;
#(
  parameter int SEG_LEN  = 16,
  parameter int NUM_SEGS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_in,
  input  logic                wr_en,
  input  logic [NUM_SEGS-2:0] tap_in,
  output logic [NUM_SEGS-1:0] tap_out,
  output logic [NUM_SEGS-1:0] tap_oe
);

  localparam int TOTAL_STAGES = SEG_LEN * NUM_SEGS;

  tsr_mode_e           mode;
  logic [NUM_SEGS-1:0] seg_din;    // next value of each segment's first stage
  logic [NUM_SEGS-1:0] seg_first;  // current first stage of each segment
  logic [NUM_SEGS-1:0] seg_tail;   // current last stage of each segment

  tsr_tap_ctrl #(.NUM_SEGS(NUM_SEGS)) u_ctrl (
    .wr_en  (wr_en),
    .mode   (mode),
    .tap_oe (tap_oe)
  );

  tsr_feed_mux #(.NUM_SEGS(NUM_SEGS)) u_mux (
    .mode     (mode),
    .ser_in   (ser_in),
    .tap_in   (tap_in),
    .seg_tail (seg_tail),
    .seg_din  (seg_din)
  );

  genvar k;
  generate
    for (k = 0; k < NUM_SEGS; k++) begin : g_seg
      tsr_segment #(.LEN(SEG_LEN)) u_seg (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (seg_din[k]),
        .head  (seg_first[k]),
        .tail  (seg_tail[k])
      );
    end
  endgenerate

  assign tap_out = seg_tail;

  if (TOTAL_STAGES < 2) begin : g_bad_size
    initial $error("tapped_shift_reg: TOTAL_STAGES must be at least 2");
  end

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int NUM_SEGS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ser_in,
  input logic                wr_en,
  input logic [NUM_SEGS-2:0] tap_in,
  input logic [NUM_SEGS-1:0] tap_out,
  input logic [NUM_SEGS-1:0] tap_oe,
  input logic [NUM_SEGS-1:0] seg_first
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tap_out == '0));

  p_serial_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (seg_first[0] == $past(ser_in)));

  p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (tap_oe == '0));

  p_oe_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (&tap_oe));

  genvar k;
  generate
    for (k = 1; k < NUM_SEGS; k++) begin : g_seg_chk
      p_tap_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (seg_first[k] == $past(tap_in[k-1])));

      p_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (seg_first[k] == $past(tap_out[k-1])));
    end
  endgenerate

endmodule

bind tapped_shift_reg tsr_checker #(.NUM_SEGS(NUM_SEGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_in    (ser_in),
  .wr_en     (wr_en),
  .tap_in    (tap_in),
  .tap_out   (tap_out),
  .tap_oe    (tap_oe),
  .seg_first (seg_first)
);

// File: tb/tapped_shift_reg_tb.sv
`timescale 1ns/1ps
module tapped_shift_reg_tb;

  localparam int SEGS  = 4;
  localparam int SLEN  = 16;
  localparam int DEPTH = SEGS * SLEN;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ser_in;
  logic            wr_en;
  logic [SEGS-2:0] tap_in;
  logic [SEGS-1:0] tap_out;
  logic [SEGS-1:0] tap_oe;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  // Reference: element 0 is stage 1, element DEPTH-1 is the last stage.
  logic model[$];

  always #4 clk = ~clk;

  tapped_shift_reg #(.SEG_LEN(SLEN), .NUM_SEGS(SEGS)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .wr_en   (wr_en),
    .tap_in  (tap_in),
    .tap_out (tap_out),
    .tap_oe  (tap_oe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [SEGS-1:0] model_taps();
    logic [SEGS-1:0] t;
    for (int k = 0; k < SEGS; k++) t[k] = model[SLEN*(k+1)-1];
    return t;
  endfunction

  task automatic model_clear();
    model.delete();
    for (int i = 0; i < DEPTH; i++) model.push_back(1'b0);
  endtask

  // Apply inputs on the falling edge, advance the reference, compare after the edge.
  task automatic step(input logic w, input logic s, input logic [SEGS-2:0] ti, input string tag);
    ser_in = s; wr_en = w; tap_in = ti;
    #1;
    check("R3 oe", {28'd0, tap_oe}, w ? 32'd0 : {28'd0, {SEGS{1'b1}}});
    model.push_front(s);
    void'(model.pop_back());
    if (w) for (int k = 1; k < SEGS; k++) model[SLEN*k] = ti[k-1];
    @(negedge clk);
    check(tag, {28'd0, tap_out}, {28'd0, model_taps()});
  endtask

  logic [DEPTH:1] pattern = 64'hA5C3_0F96_1E2D_7B48;

  initial begin
    rst_n = 1'b0; ser_in = 1'b0; wr_en = 1'b0; tap_in = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset taps", {28'd0, tap_out}, 32'd0);
    check("R3 oe in reset", {28'd0, tap_oe}, {28'd0, {SEGS{1'b1}}});
    rst_n = 1'b1;

    // Shift mode with noise on tap_in: R2, R5, R6, R7
    for (int i = 0; i < 120; i++)
      step(1'b0, 1'(($urandom >> 3) & 1), 3'($urandom), "R5 R6 R7 shift");

    // Segment load of a fixed word: R4, R8
    for (int n = 0; n < SLEN; n++) begin
      logic [SEGS-2:0] ti;
      for (int k = 1; k < SEGS; k++) ti[k-1] = pattern[SLEN*k + SLEN - n];
      step(1'b1, pattern[SLEN - n], ti, "R4 load");
    end
    // Serial readback of the word on the last tap: R8, R7
    for (int m = 0; m < DEPTH; m++) begin
      check("R8 readback", {31'd0, tap_out[SEGS-1]}, {31'd0, pattern[DEPTH - m]});
      step(1'b0, 1'b0, 3'($urandom), "R7 readback shift");
    end

    // Mixed modes toggling freely: R2, R3, R4, R5
    for (int i = 0; i < 200; i++)
      step(1'($urandom & 1), 1'(($urandom >> 5) & 1), 3'($urandom), "R2 R4 R5 mixed");

    // Asynchronous clear in the middle of activity: R1
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {28'd0, tap_out}, 32'd0);
    model_clear();
    @(negedge clk);
    check("R1 held clear", {28'd0, tap_out}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 70; i++)
      step(1'b0, 1'b1, 3'b000, "R7 ones after clear");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule